// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned 32-bit operands over many clock cycles, using one 32-bit adder. The 64-bit product comes out as a high word and a low word. A caller raises `start` for one cycle with both operands on the inputs. The block captures the operands on that edge and raises `busy`. It then processes one multiplier bit per clock. When it finishes, it drops `busy`, pulses `done` for one cycle, and holds `hi` and `lo` until a new operation is accepted.

The block keeps no separate multiplier register. The multiplier is loaded into the low half of a double-width product register. Each step tests that register's least significant bit. If the bit is set, the step adds the stored multiplicand into the upper half of the register. The whole register then moves right by one bit, with the adder's carry entering at the top. The same shift that consumes a used multiplier bit also makes room for a new product bit.

Top module: `shiftmul_top`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `hi` and `lo` are both zero.
- R2: When an operation completes, `{hi, lo}` equals the full 64-bit unsigned product of the multiplicand and multiplier captured at the accepting edge.
- R3: A `start` seen high at a rising edge while idle is accepted. `busy` is then high for exactly 32 consecutive cycles, and `done` is never high in the same cycle as `busy`.
- R4: `done` is high for exactly one cycle: the first cycle after `busy` falls.
- R5: While `busy` is high, `start` and changes on the operand inputs have no effect on the result of the operation in progress or on its timing.
- R6: After `done`, `hi` and `lo` keep their values for as long as no new `start` is accepted.
- R7: Carries out of the 32-bit addition are not lost: all-ones times all-ones gives `hi` = 0xFFFFFFFE and `lo` = 0x00000001.
- R8: A zero in either operand yields a zero product, and a multiplier of 1 returns the multiplicand in `lo` with `hi` zero.
- R9: A `start` presented in the same cycle as `done` is accepted, so operations can run back to back with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new multiplication; accepted only while idle |
| multiplicand | input | 32 | Unsigned multiplicand, captured when start is accepted |
| multiplier | input | 32 | Unsigned multiplier, captured when start is accepted |
| busy | output | 1 | High while the shift-add steps are running |
| done | output | 1 | One-cycle pulse when the product is ready |
| hi | output | 32 | Upper 32 bits of the product |
| lo | output | 32 | Lower 32 bits of the product |

## Verification
The assertions assume three things about the inputs: `rstN` is held low for at least one clock edge, `start` and the operands are stable around the rising edge, and only the accepting edge matters for operand values. The stimulus changes inputs only on the falling clock edge. It holds reset across several edges. While `busy` is high, it deliberately toggles `start` and scrambles the operands, so the assertion that a run is never cut short is exercised. The stimulus releases the mid-run `start` well before the final step, so the only starts that land in an idle cycle are intended ones.

// File: rtl/shiftmul_pkg.sv
package shiftmul_pkg;

  // Strobes sent from the sequencer to the datapath.
  typedef struct packed {
    logic load;  // capture operands and seed the product register
    logic step;  // one conditional add followed by a right shift
  } mulStrobe_t;

endpackage

// File: rtl/shiftmul_ctrl.sv
module shiftmul_ctrl
  import shiftmul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output mulStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  typedef enum logic [0:0] {ST_IDLE, ST_RUN} seqState_t;

  seqState_t        state;
  logic [CNT_W-1:0] iterCnt;
  logic             doneQ;

  always_comb begin
    strobe.load = (state == ST_IDLE) && start;
    strobe.step = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            iterCnt <= '0;
          end
        end
        ST_RUN: begin
          if (iterCnt == LAST_STEP) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end else begin
            iterCnt <= iterCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_RUN);
  assign done = doneQ;

  // Independent run-length counter used only by the checks below.
  logic [CNT_W:0] runLen;
  always_ff @(posedge clk) begin
    if (!rstN)            runLen <= '0;
    else if (strobe.load) runLen <= '0;
    else if (busy)        runLen <= runLen + 1'b1;
  end

  p_run_length_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == (CNT_W+1)'(WIDTH)));

  p_done_busy_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && iterCnt != LAST_STEP) |=> busy);

endmodule

// File: rtl/shiftmul_dp.sv
module shiftmul_dp
  import shiftmul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mulStrobe_t       strobe,
  input  logic [WIDTH-1:0] mcandIn,
  input  logic [WIDTH-1:0] mplierIn,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);

  localparam int PROD_W = 2 * WIDTH;

  logic [WIDTH-1:0]  mcandReg;
  logic [PROD_W-1:0] prodReg;
  logic [WIDTH-1:0]  addend;
  logic [WIDTH:0]    sumWide;

  // Gate the multiplicand by the current low bit of the product register.
  for (genvar i = 0; i < WIDTH; i++) begin : g_gate
    assign addend[i] = mcandReg[i] & prodReg[0];
  end

  assign sumWide = {1'b0, prodReg[PROD_W-1:WIDTH]} + {1'b0, addend};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcandReg <= '0;
      prodReg  <= '0;
    end else if (strobe.load) begin
      mcandReg <= mcandIn;
      prodReg  <= {{WIDTH{1'b0}}, mplierIn};
    end else if (strobe.step) begin
      prodReg <= {sumWide, prodReg[WIDTH-1:1]};
    end
  end

  assign hi = prodReg[PROD_W-1:WIDTH];
  assign lo = prodReg[WIDTH-1:0];

  p_seed_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (hi == '0));

  p_low_shift_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (prodReg[WIDTH-2:0] == $past(prodReg[WIDTH-1:1])));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.step) |=> $stable(prodReg));

  p_operand_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> $stable(mcandReg));

endmodule

// File: rtl/shiftmul_top.sv
module shiftmul_top
  import shiftmul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] multiplicand,
  input  logic [WIDTH-1:0] multiplier,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);

  mulStrobe_t strobe;

  shiftmul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  shiftmul_dp #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .mcandIn  (multiplicand),
    .mplierIn (multiplier),
    .hi       (hi),
    .lo       (lo)
  );

endmodule

// File: tb/shiftmul_top_test.sv
module shiftmul_top_test;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] aIn = '0;
  logic [W-1:0] bIn = '0;
  logic         busy, done;
  logic [W-1:0] hi, lo;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  shiftmul_top #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .start(start),
    .multiplicand(aIn), .multiplier(bIn),
    .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: run did not finish (actual cycles=%0d expected<=150000)", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [2*W-1:0] refProd(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] wa = {{W{1'b0}}, a};
    logic [2*W-1:0] wb = {{W{1'b0}}, b};
    return wa * wb;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Drive start with operands at a falling edge; the next rising edge accepts.
  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
    start = 1'b1; aIn = a; bIn = b;
    @(negedge clk);
    start = 1'b0; aIn = $urandom; bIn = $urandom;
  endtask

  // Called one falling edge after launch; follows the run to its done cycle.
  task automatic collect(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb, input string tag);
    int busyLen = 0;
    logic [2*W-1:0] exp = refProd(a, b);
    while (busy && busyLen < 200) begin
      if (disturb && busyLen == 2) begin start = 1'b1; aIn = $urandom; bIn = $urandom; end
      if (disturb && busyLen == 9) start = 1'b0;
      if (disturb && busyLen > 2 && busyLen < 9) begin aIn = ~aIn; bIn = bIn + 1; end
      busyLen++;
      @(negedge clk);
    end
    check(busyLen == W, {"R3 busy length ", tag}, 64'(busyLen), 64'(W));
    check(done == 1'b1, {"R4 done after busy ", tag}, 64'(done), 64'd1);
    if (disturb)
      check({hi, lo} == exp, {"R5 product with mid-run start ", tag}, {hi, lo}, exp);
    else
      check({hi, lo} == exp, {"R2 product ", tag}, {hi, lo}, exp);
  endtask

  // Full operation followed by idle cycles to confirm the pulse and hold behaviour.
  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb, input string tag);
    logic [2*W-1:0] held;
    launch(a, b);
    collect(a, b, disturb, tag);
    held = {hi, lo};
    for (int k = 0; k < 3; k++) begin
      aIn = $urandom; bIn = $urandom;
      @(negedge clk);
      if (k == 0) check(done == 1'b0, {"R4 done single cycle ", tag}, 64'(done), 64'd0);
    end
    check({hi, lo} == held, {"R6 outputs held ", tag}, {hi, lo}, held);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 reset flags", {62'd0, busy, done}, 64'd0);
    check({hi, lo} == '0, "R1 reset product", {hi, lo}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R7: carry out of the adder must reach the top of the product.
    runOp('1, '1, 1'b0, "R7 all ones");
    check({hi, lo} == 64'hFFFFFFFE_00000001, "R7 max value", {hi, lo}, 64'hFFFFFFFE_00000001);

    // R8: zero and unit operands.
    runOp(32'd0, 32'hDEADBEEF, 1'b0, "R8 zero mcand");
    check({hi, lo} == 64'd0, "R8 zero mcand result", {hi, lo}, 64'd0);
    runOp(32'h12345678, 32'd0, 1'b0, "R8 zero mplier");
    check({hi, lo} == 64'd0, "R8 zero mplier result", {hi, lo}, 64'd0);
    runOp(32'hCAFEF00D, 32'd1, 1'b0, "R8 unit mplier");
    check(hi == '0 && lo == 32'hCAFEF00D, "R8 unit result", {hi, lo}, 64'h00000000_CAFEF00D);

    runOp(32'h80000000, 32'h80000000, 1'b0, "R2 top bits");
    runOp(32'hFFFFFFFF, 32'h00000002, 1'b0, "R2 shifted ones");

    // R5: start and operand churn while busy.
    runOp(32'h0001_0003, 32'h0000_FFFF, 1'b1, "R5 directed");
    runOp($urandom, $urandom, 1'b1, "R5 random");

    // R9: start in the done cycle.
    begin
      logic [W-1:0] a1 = $urandom, b1 = $urandom, a2 = $urandom, b2 = $urandom;
      launch(a1, b1);
      collect(a1, b1, 1'b0, "R9 first");
      launch(a2, b2);
      check(busy == 1'b1, "R9 back-to-back accepted", 64'(busy), 64'd1);
      collect(a2, b2, 1'b0, "R9 second");
      @(negedge clk);
    end

    // Random operands for R2.
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] ra = $urandom;
      logic [W-1:0] rb = $urandom;
      if (n % 8 == 3) ra = ra >> (n % 29);
      if (n % 8 == 5) rb = rb | 32'h8000_0001;
      runOp(ra, rb, (n % 10 == 7), "R2 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule